// File: doc/BRIEF.md
# Dual-TAP JTAG Debug Port

This block is a serial debug port that uses the usual four JTAG signals and an active-low test reset. Two complete TAP state machines sit behind that one set of pins. The first TAP runs boundary scan and owns a bypass bit and a parameterized scan chain. The second TAP runs the debug function and owns a bypass bit, an 8-bit command (instruction) register that is shifted straight between TDI and TDO, and an interrupt register.

After a test reset the boundary-scan TAP is the active one. A host hands the pins to the debug TAP by loading the switch opcode into the boundary-scan instruction register. From then on the debug TAP follows TMS and drives TDO, and the boundary-scan TAP stays frozen. A test reset brings control back to the boundary-scan TAP, and so do five TMS-high clocks in a row.

On the CPU side there is one level-sensitive interrupt request. The host raises it by updating the interrupt register with bit 0 set. The CPU drops it with a clear input. Everything is clocked by TCK. `tdo_oe` enables the pad driver, so the pin is high-impedance whenever `tdo_oe` is low.

Top module: `jdp_debug_port`

## Requirements
- R1: When `trst_n` is low at a rising TCK edge, both TAPs go to Test-Logic-Reset and both instruction registers load 8'hFF. The boundary-scan TAP becomes active, `irq` goes low, the scan chain clears to zero, and `tdo_oe` is low from the next falling edge.
- R2: Five consecutive rising TCK edges with TMS high give the same TAP reset and make the boundary-scan TAP active again. This reset does not change `irq` and does not change the scan chain contents.
- R3: In Capture-IR an instruction register loads 8'h01. During Shift-IR, TDI enters at the MSB and TDO presents the LSB first. Update-IR makes the shifted value the current instruction.
- R4: TDI and TMS are sampled on rising TCK. TDO changes on falling TCK. `tdo_oe` is high only while the active TAP is in Shift-DR or Shift-IR.
- R5: Opcode 8'hFF, and any opcode that the active TAP does not decode, selects a 1-bit bypass register. That register captures 0, so the first bit shifted out is 0 and each later bit is the TDI value from one clock earlier.
- R6: On the boundary-scan TAP, opcode 8'h02 selects a BSC_LEN-bit chain that shifts LSB first. Capture-DR leaves its contents unchanged, so one scan reads out the data loaded by the scan before it.
- R7: When the boundary-scan TAP performs Update-IR with opcode 8'h55, the debug TAP becomes active. The debug TAP starts in Test-Logic-Reset and takes TMS from the next rising edge.
- R8: On the debug TAP, opcode 8'h0F selects the INT_W-bit interrupt register. Capture-DR loads the last updated value and Update-DR stores the shifted value.
- R9: Update-DR of the interrupt register with bit 0 set raises `irq`. The request stays high until `irq_clr` is high at a rising edge. If a set and a clear fall on the same edge, the set wins.
- R10: The inactive TAP ignores TMS and keeps its state and registers. Opcodes have meaning only on their own TAP: 8'h0F on the boundary-scan TAP and 8'h02 on the debug TAP both select bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state advances on its rising edge |
| trst_n | input | 1 | Active-low test reset, sampled on rising TCK |
| tms | input | 1 | Test mode select, routed to the active TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for the TDO pad; low means high-impedance |
| irq | output | 1 | Sticky interrupt request toward the CPU |
| irq_clr | input | 1 | CPU clear of the interrupt request, sampled on rising TCK |

## Verification
Two events can land on the same rising TCK edge: a host Update-DR that sets the interrupt, and a CPU pulse on `irq_clr`. The bench provokes this by raising `irq_clr` on exactly the clock that leaves Update-DR with bit 0 set, and then requires `irq` to stay high. Separately, a clear on its own must drop `irq`, and a soft TAP reset must leave it untouched. The switch between TAPs is judged from outputs only. For example, opcode 8'h0F returns the previously written interrupt value on one TAP and a one-bit-delayed echo of TDI on the other.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    localparam int IR_W          = 8;
    localparam int TMS_RST_CNT   = 5;

    localparam logic [IR_W-1:0] OP_BYPASS  = 8'hFF;
    localparam logic [IR_W-1:0] OP_SWITCH  = 8'h55;
    localparam logic [IR_W-1:0] OP_CHAIN   = 8'h02;
    localparam logic [IR_W-1:0] OP_INTREG  = 8'h0F;
    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic capture_dr;
        logic shift_dr;
        logic update_dr;
        logic capture_ir;
        logic shift_ir;
        logic update_ir;
        logic in_shift;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic tap_ctl_t tap_decode(input tap_state_e s);
        tap_ctl_t c;
        c.capture_dr = (s == ST_CAP_DR);
        c.shift_dr   = (s == ST_SH_DR);
        c.update_dr  = (s == ST_UPD_DR);
        c.capture_ir = (s == ST_CAP_IR);
        c.shift_ir   = (s == ST_SH_IR);
        c.update_ir  = (s == ST_UPD_IR);
        c.in_shift   = (s == ST_SH_DR) || (s == ST_SH_IR);
        return c;
    endfunction

endpackage

// File: rtl/jdp_tap.sv
module jdp_tap
    import jdp_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            en,
    input  logic            tms,
    input  logic            tdi,
    output tap_state_e      state,
    output tap_ctl_t        ctl,
    output logic [IR_W-1:0] ir,
    output logic [IR_W-1:0] ir_sh
);

    // Actions are qualified by en so a frozen TAP never touches its registers.
    always_comb begin
        ctl = en ? tap_decode(state) : '0;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= ST_TLR;
            ir    <= OP_BYPASS;
            ir_sh <= IR_CAPTURE;
        end else if (en) begin
            state <= tap_next(state, tms);
            if (ctl.capture_ir) begin
                ir_sh <= IR_CAPTURE;
            end else if (ctl.shift_ir) begin
                ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            end
            if (ctl.update_ir) begin
                ir <= ir_sh;
            end else if (state == ST_TLR) begin
                ir <= OP_BYPASS;
            end
        end
    end

    AST_FROZEN_WHEN_IDLE: assert property (@(posedge tck) disable iff (rst)
        !en |=> $stable(state) && $stable(ir)); // R10

    AST_IR_CAPTURE_VALUE: assert property (@(posedge tck) disable iff (rst)
        ctl.capture_ir |=> (ir_sh == IR_CAPTURE)); // R3

endmodule

// File: rtl/jdp_bscan_dr.sv
module jdp_bscan_dr
    import jdp_pkg::*;
#(
    parameter int BSC_LEN = 16
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tap_rst,
    input  tap_ctl_t        ctl,
    input  logic [IR_W-1:0] ir,
    input  logic            tdi,
    output logic            dr_tdo
);

    logic               byp;
    logic [BSC_LEN-1:0] chain;
    logic               sel_chain;

    assign sel_chain = (ir == OP_CHAIN);
    assign dr_tdo    = sel_chain ? chain[0] : byp;

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            byp <= 1'b0;
        end else if (ctl.capture_dr) begin
            byp <= 1'b0;
        end else if (ctl.shift_dr) begin
            byp <= tdi;
        end
    end

    // The chain only clears on the pin reset; capture keeps its contents.
    always_ff @(posedge tck) begin
        if (rst) begin
            chain <= '0;
        end else if (ctl.shift_dr && sel_chain) begin
            chain <= {tdi, chain[BSC_LEN-1:1]};
        end
    end

    AST_CHAIN_HOLDS: assert property (@(posedge tck) disable iff (rst)
        !ctl.shift_dr |=> $stable(chain)); // R6

endmodule

// File: rtl/jdp_debug_dr.sv
module jdp_debug_dr
    import jdp_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tap_rst,
    input  tap_ctl_t        ctl,
    input  logic [IR_W-1:0] ir,
    input  logic            tdi,
    input  logic            irq_clr,
    output logic            dr_tdo,
    output logic            irq
);

    logic             byp;
    logic [INT_W-1:0] int_sh;
    logic [INT_W-1:0] int_reg;
    logic             sel_int;
    logic             irq_set;

    assign sel_int = (ir == OP_INTREG);
    assign dr_tdo  = sel_int ? int_sh[0] : byp;
    assign irq_set = ctl.update_dr && sel_int && int_sh[0];

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            byp     <= 1'b0;
            int_sh  <= '0;
            int_reg <= '0;
        end else begin
            if (ctl.capture_dr) begin
                byp <= 1'b0;
            end else if (ctl.shift_dr) begin
                byp <= tdi;
            end
            if (sel_int) begin
                if (ctl.capture_dr) begin
                    int_sh <= int_reg;
                end else if (ctl.shift_dr) begin
                    int_sh <= {tdi, int_sh[INT_W-1:1]};
                end
                if (ctl.update_dr) begin
                    int_reg <= int_sh;
                end
            end
        end
    end

    // Set has priority over a simultaneous CPU clear.
    always_ff @(posedge tck) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    AST_IRQ_RAISE: assert property (@(posedge tck) disable iff (rst)
        (ctl.update_dr && sel_int && int_sh[0]) |=> irq); // R9

    AST_IRQ_STICKY: assert property (@(posedge tck) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9

    AST_IRQ_CLEAR: assert property (@(posedge tck) disable iff (rst)
        (irq_clr && !ctl.update_dr) |=> !irq); // R9

endmodule

// File: rtl/jdp_debug_port.sv
module jdp_debug_port
    import jdp_pkg::*;
#(
    parameter int BSC_LEN = 16,
    parameter int INT_W   = 8
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic irq,
    input  logic irq_clr
);

    localparam int CNT_W = $clog2(TMS_RST_CNT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMS_RST_CNT - 1);

    logic             rst;
    logic             soft_rst;
    logic             tap_rst;
    logic [CNT_W-1:0] tms_cnt;
    logic             sel_dbg;

    tap_state_e       bs_state,  dbg_state;
    tap_ctl_t         bs_ctl,    dbg_ctl;
    logic [IR_W-1:0]  bs_ir,     dbg_ir;
    logic [IR_W-1:0]  bs_ir_sh,  dbg_ir_sh;
    logic             bs_dr_tdo, dbg_dr_tdo;
    logic             bs_out,    dbg_out;

    assign rst      = ~trst_n;
    assign soft_rst = tms && (tms_cnt == CNT_LAST);
    assign tap_rst  = rst || soft_rst;

    // Consecutive TMS-high counter, watched on the pins for both TAPs.
    always_ff @(posedge tck) begin
        if (rst || !tms) begin
            tms_cnt <= '0;
        end else if (tms_cnt != CNT_LAST) begin
            tms_cnt <= tms_cnt + 1'b1;
        end
    end

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            sel_dbg <= 1'b0;
        end else if (bs_ctl.update_ir && (bs_ir_sh == OP_SWITCH)) begin
            sel_dbg <= 1'b1;
        end
    end

    jdp_tap u_bs_tap (
        .tck   (tck),
        .rst   (tap_rst),
        .en    (~sel_dbg),
        .tms   (tms),
        .tdi   (tdi),
        .state (bs_state),
        .ctl   (bs_ctl),
        .ir    (bs_ir),
        .ir_sh (bs_ir_sh)
    );

    jdp_tap u_dbg_tap (
        .tck   (tck),
        .rst   (tap_rst),
        .en    (sel_dbg),
        .tms   (tms),
        .tdi   (tdi),
        .state (dbg_state),
        .ctl   (dbg_ctl),
        .ir    (dbg_ir),
        .ir_sh (dbg_ir_sh)
    );

    jdp_bscan_dr #(.BSC_LEN(BSC_LEN)) u_bs_dr (
        .tck     (tck),
        .rst     (rst),
        .tap_rst (tap_rst),
        .ctl     (bs_ctl),
        .ir      (bs_ir),
        .tdi     (tdi),
        .dr_tdo  (bs_dr_tdo)
    );

    jdp_debug_dr #(.INT_W(INT_W)) u_dbg_dr (
        .tck     (tck),
        .rst     (rst),
        .tap_rst (tap_rst),
        .ctl     (dbg_ctl),
        .ir      (dbg_ir),
        .tdi     (tdi),
        .irq_clr (irq_clr),
        .dr_tdo  (dbg_dr_tdo),
        .irq     (irq)
    );

    assign bs_out  = (bs_state  == ST_SH_IR) ? bs_ir_sh[0]  : bs_dr_tdo;
    assign dbg_out = (dbg_state == ST_SH_IR) ? dbg_ir_sh[0] : dbg_dr_tdo;

    // Falling-edge output stage for the pin.
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= sel_dbg ? dbg_out : bs_out;
            tdo_oe <= bs_ctl.in_shift | dbg_ctl.in_shift;
        end
    end

    AST_SWITCH_SOURCE: assert property (@(posedge tck) disable iff (rst)
        $rose(sel_dbg) |-> ($past(bs_state) == ST_UPD_IR) && ($past(bs_ir_sh) == OP_SWITCH)); // R7

    AST_RETURN_ON_RESET: assert property (@(posedge tck) disable iff (rst)
        $fell(sel_dbg) |-> $past(tap_rst)); // R2

    AST_SOFT_RESET_TLR: assert property (@(posedge tck) disable iff (rst)
        soft_rst |=> (bs_state == ST_TLR) && (dbg_state == ST_TLR) && !sel_dbg); // R2

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (sel_dbg ? (dbg_state == ST_SH_DR || dbg_state == ST_SH_IR)
                            : (bs_state  == ST_SH_DR || bs_state  == ST_SH_IR))); // R4

endmodule

// File: tb/jdp_debug_port_tb.sv
`timescale 1ns/1ps
module jdp_debug_port_tb;

    localparam int BSC_LEN = 16;
    localparam int INT_W   = 8;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic irq_clr = 1'b0;
    logic tdo, tdo_oe, irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #4 tck = ~tck;

    jdp_debug_port #(.BSC_LEN(BSC_LEN), .INT_W(INT_W)) u_dut (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .tdi     (tdi),
        .tdo     (tdo),
        .tdo_oe  (tdo_oe),
        .irq     (irq),
        .irq_clr (irq_clr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pairs expected words with observed words.
    initial begin
        forever begin
            @(negedge tck);
            while (exp_q.size() > 0 && act_q.size() > 0) begin
                check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    // One TCK cycle: drive after the falling edge, sample TDO there.
    task automatic step(input logic m, input logic d, input logic c,
                        output logic o, output logic oe);
        @(negedge tck);
        #1;
        tms = m; tdi = d; irq_clr = c;
        o = tdo; oe = tdo_oe;
        @(posedge tck);
    endtask

    task automatic idle(input logic m);
        logic o, oe;
        step(m, 1'b0, 1'b0, o, oe);
    endtask

    task automatic shift_ir(input logic [7:0] val, input string tag);
        logic o, oe;
        logic [7:0] got;
        logic oe_all;
        exp_q.push_back(32'h01);
        tag_q.push_back(tag);
        oe_all = 1'b1;
        idle(1); idle(1); idle(0); idle(0);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, val[i], 1'b0, o, oe);
            got[i] = o;
            oe_all = oe_all & oe;
        end
        idle(1); idle(0);
        act_q.push_back({24'h0, got});
        check("R4 tdo_oe high through Shift-IR", {31'h0, oe_all}, 32'h1);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din,
                            input logic [31:0] dexp, input string tag, input logic clr);
        logic o, oe;
        logic [31:0] got;
        exp_q.push_back(dexp);
        tag_q.push_back(tag);
        got = '0;
        idle(1); idle(0); idle(0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], 1'b0, o, oe);
            got[i] = o;
        end
        idle(1);
        step(1'b0, 1'b0, clr, o, oe);
        act_q.push_back(got);
        @(negedge tck); #1 irq_clr = 1'b0;
    endtask

    function automatic logic [31:0] echo(input logic [31:0] din, input int n);
        return (din << 1) & ((32'h1 << n) - 1);
    endfunction

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic o, oe;
        // R1: reset
        repeat (3) idle(1);
        @(negedge tck); #1 trst_n = 1'b1;
        check("R1 tdo_oe low after reset", {31'h0, tdo_oe}, 32'h0);
        check("R1 irq low after reset", {31'h0, irq}, 32'h0);
        idle(0);
        step(1'b0, 1'b0, 1'b0, o, oe);
        check("R4 tdo_oe low in Run-Test/Idle", {31'h0, oe}, 32'h0);

        // R3, R6: chain access on the boundary-scan TAP
        shift_ir(8'h02, "R3 capture-IR on boundary TAP");
        shift_dr(BSC_LEN, 32'hA5C3, 32'h0, "R6 chain initial contents", 1'b0);
        shift_dr(BSC_LEN, 32'h1234, 32'hA5C3, "R6 chain returns prior scan", 1'b0);

        // R5: bypass and unknown opcodes
        shift_ir(8'hFF, "R3 capture-IR before bypass");
        shift_dr(8, 32'hB6, echo(32'hB6, 8), "R5 bypass echo", 1'b0);
        shift_ir(8'h3C, "R3 capture-IR before unknown");
        shift_dr(8, 32'hE7, echo(32'hE7, 8), "R5 unknown opcode is bypass", 1'b0);

        // R10: debug opcode on boundary TAP is bypass
        shift_ir(8'h0F, "R3 capture-IR with 0F on boundary TAP");
        shift_dr(8, 32'h81, echo(32'h81, 8), "R10 0F on boundary TAP is bypass", 1'b0);

        // R7: switch to the debug TAP
        shift_ir(8'h55, "R3 capture-IR before switch");
        idle(0);
        shift_ir(8'h0F, "R7 debug TAP captures IR");
        shift_dr(8, 32'h81, 32'h00, "R8 interrupt register initial value", 1'b0);
        @(negedge tck); #2;
        check("R9 irq raised by update with bit0", {31'h0, irq}, 32'h1);
        idle(0); idle(0);
        @(negedge tck); #2;
        check("R9 irq sticky without clear", {31'h0, irq}, 32'h1);
        step(1'b0, 1'b0, 1'b1, o, oe);
        @(negedge tck); #2 irq_clr = 1'b0;
        check("R9 irq cleared by irq_clr", {31'h0, irq}, 32'h0);

        shift_dr(8, 32'h80, 32'h81, "R8 interrupt register readback", 1'b0);
        @(negedge tck); #2;
        check("R9 no irq when bit0 clear", {31'h0, irq}, 32'h0);
        shift_dr(8, 32'h03, 32'h80, "R8 interrupt register readback 2", 1'b1);
        @(negedge tck); #2;
        check("R9 set wins over same-edge clear", {31'h0, irq}, 32'h1);

        // R10: chain opcode on debug TAP is bypass
        shift_ir(8'h02, "R3 capture-IR with 02 on debug TAP");
        shift_dr(8, 32'h55, echo(32'h55, 8), "R10 02 on debug TAP is bypass", 1'b0);

        // R2: five TMS-high clocks return to the boundary-scan TAP
        repeat (5) idle(1);
        idle(0);
        @(negedge tck); #2;
        check("R2 irq kept across TMS reset", {31'h0, irq}, 32'h1);
        shift_dr(8, 32'h0F, echo(32'h0F, 8), "R2 boundary TAP in bypass after TMS reset", 1'b0);
        shift_ir(8'h02, "R3 capture-IR after TMS reset");
        shift_dr(BSC_LEN, 32'h0, 32'h1234, "R10 chain untouched while debug TAP active", 1'b0);

        // R1: pin reset while the debug TAP is active
        shift_ir(8'h55, "R3 capture-IR before second switch");
        idle(0);
        @(negedge tck); #1 trst_n = 1'b0;
        @(posedge tck);
        @(negedge tck); #1 trst_n = 1'b1;
        #1;
        check("R1 irq cleared by trst", {31'h0, irq}, 32'h0);
        idle(0);
        shift_ir(8'h0F, "R1 boundary TAP active after trst");
        shift_dr(8, 32'h81, echo(32'h81, 8), "R1 boundary TAP bypass after trst", 1'b0);
        shift_ir(8'h02, "R3 capture-IR after trst");
        shift_dr(BSC_LEN, 32'h0, 32'h0, "R1 chain cleared by trst", 1'b0);

        repeat (3) @(negedge tck);
        if (exp_q.size() != 0 || act_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard residue actual=%0d expected=%0d", act_q.size(), exp_q.size());
        end
        summary();
        $finish;
    end

endmodule